// File: doc/BRIEF.md
# Bidirectional GPIO Port with Change Interrupt

This block is an 8-bit general-purpose I/O port that a CPU controls through two registers. The direction register sets each pin as an input (bit = 1, driver off) or an output (bit = 0). The data register holds the output latch. The port has separate read and write strobes for each register, an 8-bit write bus and an 8-bit read bus. For every pin it produces an output value, an output enable and a weak pull-up enable. All pin inputs pass through a two-flop synchroniser. A read of the data register returns those synchronised levels.

The upper nibble of the port carries change detection. Each pin in that group that is set as an input is compared against a snapshot. The snapshot is taken whenever software reads or writes the data register. Any difference raises a live wake request and sets a sticky change flag. The flag cannot be cleared while the difference remains, so software must access the port before its clear strobe takes effect. An active-low global control, which comes from an external option register, turns on the pull-ups of the pins that are inputs.

Top module: `gpio_chg_port`

## Requirements
- R1: `pinOe[i]` equals the inverse of direction bit i. `pinOut` always equals the output latch. A direction read (`dirRdEn`) returns the direction register on `rdData`.
- R2: Out of reset, `pullEn[i]` is 1 exactly when `pullCtlN` is 0 and direction bit i is 1 (input). No pin ever has its pull-up and its output enable both active.
- R3: While `rstN` is low, `pullEn` is all zeros whatever `pullCtlN` is. Reset clears the output latch, the snapshot and `chgFlag`, and sets the direction register to 0xFF (all pins inputs).
- R4: A data read (`dataRdEn`) returns the pin levels after a two-flop synchroniser, not the output latch. A pin change driven before a rising edge is visible in the read two rising edges later.
- R5: Only pins 7 down to 4 take part in change detection, and only while their direction bit is 1. A change on pins 3 to 0, or on an upper pin set as an output, leaves `wakeReq` and `chgFlag` at 0.
- R6: `wakeReq` is high in every cycle where a participating synchronised pin differs from the snapshot. It rises two edges after the pin changes.
- R7: `chgFlag` is set at the edge after any mismatch and stays set until cleared. While a mismatch exists, a `flagClr` pulse has no effect, because set wins over clear.
- R8: A data read or a data write loads the snapshot from the synchronised pins, which ends the mismatch. After that, a `flagClr` pulse clears `chgFlag` at the next edge.
- R9: A data write while a pin is an input updates its latch. That value is driven on the pin once the pin is switched to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| dataWrEn | input | 1 | Write strobe for the data register (output latch) |
| dataRdEn | input | 1 | Read strobe for the data register (pin levels) |
| dirWrEn | input | 1 | Write strobe for the direction register |
| dirRdEn | input | 1 | Read strobe for the direction register |
| wrData | input | 8 | Write data for both registers |
| rdData | output | 8 | Read data, zero when no read strobe is active |
| flagClr | input | 1 | Software clear of the change flag |
| pullCtlN | input | 1 | Global pull-up control, active low |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Output latch toward the pad drivers |
| pinOe | output | 8 | Per-pin driver enable (1 = drive) |
| pullEn | output | 8 | Per-pin weak pull-up enable |
| chgFlag | output | 1 | Sticky change flag |
| wakeReq | output | 1 | Live change indication for leaving sleep |

## Verification
The assertions assume that at most one bus strobe is active in a cycle. They also assume that `flagClr` is a single-cycle pulse and that pin levels stay stable long enough to cross the synchroniser. The stimulus changes pins and strobes only at falling edges and raises one strobe at a time. It then waits at least two rising edges before judging any result that depends on a pin level. Pins are held at zero through reset, so the snapshot and the synchronised levels agree when reset is released.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic latchWr;   // load the output latch
    logic dirWr;     // load the direction register
    logic snapLoad;  // refresh the change-detect snapshot
    logic selData;   // drive synchronised pins on the read bus
    logic selDir;    // drive direction register on the read bus
  } portStrobe_t;

endpackage

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWrEn,
  input  logic             dataRdEn,
  input  logic             dirWrEn,
  input  logic             dirRdEn,
  input  logic             flagClr,
  input  logic             pullCtlN,
  input  logic [WIDTH-1:0] dirReg,
  input  logic             mismatch,
  output portStrobe_t      strb,
  output logic [WIDTH-1:0] pullEn,
  output logic             chgFlag
);

  // Bus decode: any data access refreshes the snapshot
  always_comb begin
    strb.latchWr  = dataWrEn;
    strb.dirWr    = dirWrEn;
    strb.snapLoad = dataWrEn | dataRdEn;
    strb.selData  = dataRdEn;
    strb.selDir   = dirRdEn & ~dataRdEn;
  end

  // Pull-ups: held off in reset, else global enable gated by input direction
  always_comb begin
    if (!rstN) pullEn = '0;
    else       pullEn = {WIDTH{~pullCtlN}} & dirReg;
  end

  // Sticky flag, set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)         chgFlag <= 1'b0;
    else if (mismatch) chgFlag <= 1'b1;
    else if (flagClr)  chgFlag <= 1'b0;
  end

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |=> chgFlag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chgFlag && !flagClr) |=> chgFlag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !mismatch) |=> !chgFlag);

endmodule

// File: rtl/gpio_chg_datapath.sv
module gpio_chg_datapath
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int IOC_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] dirReg,
  output logic             mismatch
);

  localparam logic [WIDTH-1:0] IOC_MASK = {WIDTH{1'b1}} << IOC_LO;

  logic [WIDTH-1:0] outLatch;
  logic [WIDTH-1:0] snapshot;
  logic [WIDTH-1:0] syncIn;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];
  logic [WIDTH-1:0] diffBits;

  // Input synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN)       syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= pinIn;
        else             syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign syncIn = syncStage[SYNC_STAGES-1];

  // Registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLatch <= '0;
      dirReg   <= '1;
      snapshot <= '0;
    end else begin
      if (strb.latchWr)  outLatch <= wrData;
      if (strb.dirWr)    dirReg   <= wrData;
      if (strb.snapLoad) snapshot <= syncIn;
    end
  end

  assign pinOut = outLatch;
  assign pinOe  = ~dirReg;

  // Per-pin compare, only upper pins configured as inputs
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
      if (IOC_MASK[i]) begin : g_ioc
        assign diffBits[i] = dirReg[i] & (syncIn[i] ^ snapshot[i]);
      end else begin : g_plain
        assign diffBits[i] = 1'b0;
      end
    end
  endgenerate
  assign mismatch = |diffBits;

  always_comb begin
    if (strb.selData)     rdData = syncIn;
    else if (strb.selDir) rdData = dirReg;
    else                  rdData = '0;
  end

  // R1
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.dirWr |=> (pinOe == ~$past(wrData)));

  // R8
  snap_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.snapLoad && $stable(pinIn) && $stable(syncIn)) |=> !mismatch);

endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int IOC_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWrEn,
  input  logic             dataRdEn,
  input  logic             dirWrEn,
  input  logic             dirRdEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic             flagClr,
  input  logic             pullCtlN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pullEn,
  output logic             chgFlag,
  output logic             wakeReq
);

  portStrobe_t      strb;
  logic [WIDTH-1:0] dirReg;
  logic             mismatch;

  gpio_chg_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dataWrEn (dataWrEn),
    .dataRdEn (dataRdEn),
    .dirWrEn  (dirWrEn),
    .dirRdEn  (dirRdEn),
    .flagClr  (flagClr),
    .pullCtlN (pullCtlN),
    .dirReg   (dirReg),
    .mismatch (mismatch),
    .strb     (strb),
    .pullEn   (pullEn),
    .chgFlag  (chgFlag)
  );

  gpio_chg_datapath #(
    .WIDTH       (WIDTH),
    .IOC_LO      (IOC_LO),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .rdData   (rdData),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .dirReg   (dirReg),
    .mismatch (mismatch)
  );

  assign wakeReq = mismatch;

  // R2
  pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullEn & pinOe) == '0);

  // R3
  pull_reset_chk: assert property (@(posedge clk)
    !rstN |-> (pullEn == '0));

  // R6
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> chgFlag);

endmodule

// File: tb/gpio_chg_port_bench.sv
`timescale 1ns/1ps
module gpio_chg_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dataWrEn = 1'b0, dataRdEn = 1'b0, dirWrEn = 1'b0, dirRdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       flagClr = 1'b0;
  logic       pullCtlN = 1'b0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut, pinOe, pullEn;
  logic       chgFlag, wakeReq;

  int testCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  gpio_chg_port u_gpio_chg_port (
    .clk(clk), .rstN(rstN), .dataWrEn(dataWrEn), .dataRdEn(dataRdEn),
    .dirWrEn(dirWrEn), .dirRdEn(dirRdEn), .wrData(wrData), .rdData(rdData),
    .flagClr(flagClr), .pullCtlN(pullCtlN), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .pullEn(pullEn), .chgFlag(chgFlag), .wakeReq(wakeReq)
  );

  // {direction, latch value, pin level, 7'b0 + pullCtlN}
  localparam logic [31:0] VECS [6] = '{
    32'hFF_00_5A_00, 32'h00_A5_3C_00, 32'hCF_12_F0_00,
    32'h0F_F0_81_01, 32'hAA_55_FF_00, 32'h33_CC_00_01
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wrDir(input logic [7:0] v);
    dirWrEn = 1'b1; wrData = v; @(negedge clk); dirWrEn = 1'b0;
  endtask

  task automatic wrPort(input logic [7:0] v);
    dataWrEn = 1'b1; wrData = v; @(negedge clk); dataWrEn = 1'b0;
  endtask

  task automatic rdPort(output logic [7:0] v);
    dataRdEn = 1'b1; #1 v = rdData; @(negedge clk); dataRdEn = 1'b0;
  endtask

  task automatic rdDir(output logic [7:0] v);
    dirRdEn = 1'b1; #1 v = rdData; @(negedge clk); dirRdEn = 1'b0;
  endtask

  task automatic pulseClr();
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    // Reset state with pull-ups requested
    idle(3);
    chk("R3", "pullEn in reset", pullEn, 8'h00);
    chk("R3", "pinOe in reset", pinOe, 8'h00);
    chk("R3", "latch in reset", pinOut, 8'h00);
    chk("R3", "flag in reset", {7'b0, chgFlag}, 8'h00);
    rstN = 1'b1;
    idle(1);
    rdDir(rv);
    chk("R3", "direction after reset", rv, 8'hFF);
    chk("R2", "pullEn after reset", pullEn, 8'hFF);

    // Vector walk
    foreach (VECS[v]) begin
      logic [7:0] d, o, p;
      d = VECS[v][31:24]; o = VECS[v][23:16]; p = VECS[v][15:8];
      pullCtlN = VECS[v][0];
      wrDir(d);
      wrPort(o);
      pinIn = p;
      idle(3);
      chk("R1", "pinOe", pinOe, ~d);
      chk("R1", "pinOut", pinOut, o);
      chk("R2", "pullEn", pullEn, pullCtlN ? 8'h00 : d);
      rdPort(rv);
      chk("R4", "pin read", rv, p);
      rdDir(rv);
      chk("R1", "direction read", rv, d);
    end

    // Quiet start for change tests
    pullCtlN = 1'b0;
    wrDir(8'hFF);
    pinIn = 8'h00;
    idle(3);
    rdPort(rv);
    pulseClr();
    chk("R8", "flag cleared after access", {7'b0, chgFlag}, 8'h00);

    // Upper pin change: timing of wake and flag
    pinIn = 8'h20;
    idle(1);
    chk("R6", "wake after one edge", {7'b0, wakeReq}, 8'h00);
    idle(1);
    chk("R6", "wake after two edges", {7'b0, wakeReq}, 8'h01);
    chk("R7", "flag not yet set", {7'b0, chgFlag}, 8'h00);
    idle(1);
    chk("R7", "flag set", {7'b0, chgFlag}, 8'h01);
    pulseClr();
    chk("R7", "clear ignored during mismatch", {7'b0, chgFlag}, 8'h01);
    rdPort(rv);
    chk("R4", "read shows new pin", rv, 8'h20);
    chk("R8", "wake ends after read", {7'b0, wakeReq}, 8'h00);
    chk("R8", "flag still set after read", {7'b0, chgFlag}, 8'h01);
    pulseClr();
    chk("R8", "flag cleared after read", {7'b0, chgFlag}, 8'h00);

    // Lower pins never trigger
    pinIn = 8'h2F;
    idle(5);
    chk("R5", "lower pin wake", {7'b0, wakeReq}, 8'h00);
    chk("R5", "lower pin flag", {7'b0, chgFlag}, 8'h00);

    // Upper pin set as output is excluded
    wrDir(8'h7F);
    pinIn = 8'hAF;
    idle(5);
    chk("R5", "output pin wake", {7'b0, wakeReq}, 8'h00);
    chk("R5", "output pin flag", {7'b0, chgFlag}, 8'h00);

    // Write also refreshes the snapshot
    wrDir(8'hFF);
    idle(1);
    chk("R6", "pin7 joins on input", {7'b0, wakeReq}, 8'h01);
    idle(1);
    wrPort(8'hA5);
    chk("R8", "wake ends after write", {7'b0, wakeReq}, 8'h00);
    pulseClr();
    chk("R8", "flag cleared after write", {7'b0, chgFlag}, 8'h00);

    // Latch written as input drives once switched to output
    chk("R9", "no drive while input", pinOe, 8'h00);
    wrDir(8'h00);
    chk("R9", "drive enabled", pinOe, 8'hFF);
    chk("R9", "latched value driven", pinOut, 8'hA5);
    rdPort(rv);
    chk("R4", "read returns pins not latch", rv, 8'hAF);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule